// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets a clocked host read and write an external asynchronous static RAM of 8192 bytes. The RAM has one bidirectional 8-bit data bus and two chip selects of opposite polarity: one is active low and one is active high. It also has an active-low write strobe and an active-low output enable. The host issues a request with a read/write select, an address and write data. The controller answers with a one-cycle acknowledge. On a read, the captured byte is presented on the read data port in the same cycle as the acknowledge.

The controller turns each request into a fixed sequence of strobe cycles. A write sets up the address first, then selects the RAM and drives the bus. It pulses the write strobe for a parameterised number of cycles and keeps the data on the bus for one more cycle after the strobe rises. A read selects the RAM and opens the output enable in the same cycle. It holds both for the access time, rounded up to whole clock cycles, and samples the bus at the end. It then closes both together. The output enable is opened only while the controller's own bus drivers are off.

A power-down input takes the active-high select low, which puts the RAM in standby. It keeps every other strobe inactive, abandons any transfer in flight and blocks new requests. All memory-side outputs come from flops.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, the active-low select, the write strobe and the output enable are high. The active-high select is low, ack is low and the controller does not drive the data bus.
- R2: An accepted write shows one cycle with all strobes inactive and the new address on mem_addr. Next comes one cycle with the active-low select low and the bus driven by the controller. Next, the write strobe is low for WR_PULSE_CYC cycles (default 3). Next comes one cycle with the write strobe high, the select still low and the data still driven. The byte is then stored at the address.
- R3: The output enable stays high in every cycle in which the write strobe is low.
- R4: The controller never drives the data bus in a cycle in which the output enable is low.
- R5: An accepted read shows one address setup cycle with all strobes inactive. The active-low select and the output enable then fall together and stay low for ceil(T_ACCESS_PS / CLK_PERIOD_PS) cycles, which is 14 at the defaults. Both then rise in the same cycle.
- R6: ack is high for exactly one cycle per completed transfer. For a write, it comes in the cycle after the hold cycle. For a read, it comes in the cycle in which the select and output enable rise, and rdata carries the byte sampled at the end of the access window.
- R7: After a read, the acknowledge cycle and the following cycle both have all strobes inactive. A request is first accepted in that following cycle, so a write after a read never finds the bus still turned toward the RAM.
- R8: One cycle after power-down is raised, mem_e2 is low and all other strobes are inactive, and the controller's bus drivers are off. A transfer in flight is abandoned without ack. A write abandoned before its strobe falls leaves the memory unchanged.
- R9: A request is accepted only in an idle cycle without power-down. A request presented during a transfer, or while power-down is high, is ignored, and no transfer happens for it.
- R10: mem_addr does not change while the active-low select is low.
- R11: The write strobe is high in the cycle before the controller stops driving the bus, unless power-down ends the transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pdown | input | 1 | Power-down: standby via the active-high select, blocks requests |
| req | input | 1 | Host request, sampled only in idle cycles |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 13 | Word address |
| wdata | input | 8 | Byte to write |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte read, valid with ack of a read |
| mem_addr | output | 13 | Address to the RAM |
| mem_e1_n | output | 1 | Active-low chip select |
| mem_e2 | output | 1 | Active-high chip select, low in standby |
| mem_w_n | output | 1 | Active-low write strobe |
| mem_g_n | output | 1 | Active-low output enable |
| mem_dq | inout | 8 | Shared data bus |

## Verification
The assertions check, on every cycle, the properties that hold at every instant. The controller never drives the bus while the output enable is low, and the output enable never falls during a write pulse. Standby forces every strobe inactive, the address stays still while selected, ack never lasts two cycles, and the write strobe rises before the data is released. The bench's scenarios are needed for the rest: the exact cycle counts of the write pulse and read window, stored and returned bytes, the read-to-write turnaround gap, and requests dropped while busy or in power-down. They also cover transfers abandoned by power-down. A behavioural memory on the bus returns data only late in the access window, so sampling too early shows up as wrong data.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WDRV,
    ST_WPUL,
    ST_WHLD,
    ST_RACC,
    ST_TURN
  } st_e;

  typedef struct packed {
    logic e1_n;
    logic w_n;
    logic g_n;
    logic dq_oe;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{e1_n: 1'b1, w_n: 1'b1, g_n: 1'b1, dq_oe: 1'b0};

  // Memory-side strobe pattern for each controller state.
  function automatic strobe_t strobe_of(st_e s);
    strobe_t r;
    r = STROBE_IDLE;
    case (s)
      ST_WDRV, ST_WHLD: begin
        r.e1_n  = 1'b0;
        r.dq_oe = 1'b1;
      end
      ST_WPUL: begin
        r.e1_n  = 1'b0;
        r.dq_oe = 1'b1;
        r.w_n   = 1'b0;
      end
      ST_RACC: begin
        r.e1_n = 1'b0;
        r.g_n  = 1'b0;
      end
      default: ;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int WR_CYC = 3,
  parameter int RD_CYC = 14
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    pdown,
  input  logic    req,
  input  logic    we,
  output logic    accept,
  output logic    capture,
  output strobe_t strb,
  output logic    e2,
  output logic    ack
);

  localparam int MAXC  = (WR_CYC > RD_CYC) ? WR_CYC : RD_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  st_e              state_q, state_d;
  logic             we_q;
  logic             tmr_zero;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  strobe_t          strb_q;
  logic             e2_q, ack_q;

  assign accept  = (state_q == ST_IDLE) && req && !pdown;
  assign capture = (state_q == ST_RACC) && tmr_zero && !pdown;

  always_comb begin
    state_d = state_q;
    if (pdown) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE:  if (req) state_d = ST_SETUP;
        ST_SETUP: state_d = we_q ? ST_WDRV : ST_RACC;
        ST_WDRV:  state_d = ST_WPUL;
        ST_WPUL:  if (tmr_zero) state_d = ST_WHLD;
        ST_WHLD:  state_d = ST_IDLE;
        ST_RACC:  if (tmr_zero) state_d = ST_TURN;
        ST_TURN:  state_d = ST_IDLE;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  // Load the window counter on entry to a timed state.
  assign tmr_load = (state_d != state_q) && ((state_d == ST_WPUL) || (state_d == ST_RACC));
  assign tmr_val  = (state_d == ST_WPUL) ? CNT_W'(WR_CYC - 1) : CNT_W'(RD_CYC - 1);

  sram_ctrl_timer #(.CNT_W(CNT_W)) i_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      we_q    <= 1'b0;
      strb_q  <= STROBE_IDLE;
      e2_q    <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) we_q <= we;
      strb_q  <= strobe_of(state_d);
      e2_q    <= !pdown;
      ack_q   <= !pdown && ((state_q == ST_WHLD) ||
                            ((state_q == ST_RACC) && tmr_zero));
    end
  end

  assign strb = strb_q;
  assign e2   = e2_q;
  assign ack  = ack_q;

endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath #(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          capture,
  input  logic [DW-1:0] dq_in,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] dq_out,
  output logic [DW-1:0] rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr <= '0;
      dq_out   <= '0;
      rdata    <= '0;
    end else begin
      if (accept) begin
        mem_addr <= addr;
        dq_out   <= wdata;
      end
      if (capture) rdata <= dq_in;
    end
  end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 13,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_PS = 5000,
  parameter int T_ACCESS_PS   = 70000,
  parameter int WR_PULSE_CYC  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pdown,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_e1_n,
  output logic              mem_e2,
  output logic              mem_w_n,
  output logic              mem_g_n,
  inout  wire  [DATA_W-1:0] mem_dq
);

  localparam int RD_RAW = (T_ACCESS_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int RD_CYC = (RD_RAW < 1) ? 1 : RD_RAW;
  localparam int WR_CYC = (WR_PULSE_CYC < 1) ? 1 : WR_PULSE_CYC;

  logic              accept, capture;
  strobe_t           strb;
  logic              dq_oe;
  logic [DATA_W-1:0] dq_out;

  sram_ctrl_fsm #(.WR_CYC(WR_CYC), .RD_CYC(RD_CYC)) i_fsm (
    .clk     (clk),
    .rst     (rst),
    .pdown   (pdown),
    .req     (req),
    .we      (we),
    .accept  (accept),
    .capture (capture),
    .strb    (strb),
    .e2      (mem_e2),
    .ack     (ack)
  );

  sram_ctrl_datapath #(.AW(ADDR_W), .DW(DATA_W)) i_dp (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .addr     (addr),
    .wdata    (wdata),
    .capture  (capture),
    .dq_in    (mem_dq),
    .mem_addr (mem_addr),
    .dq_out   (dq_out),
    .rdata    (rdata)
  );

  assign mem_e1_n = strb.e1_n;
  assign mem_w_n  = strb.w_n;
  assign mem_g_n  = strb.g_n;
  assign dq_oe    = strb.dq_oe;
  assign mem_dq   = dq_oe ? dq_out : {DATA_W{1'bz}};

endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
  parameter int AW = 13
) (
  input logic          clk,
  input logic          rst,
  input logic          e1_n,
  input logic          e2,
  input logic          w_n,
  input logic          g_n,
  input logic          dq_oe,
  input logic          ack,
  input logic [AW-1:0] mem_addr
);

  AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (rst)
    !e2 |-> (e1_n && w_n && g_n && !dq_oe)); // R8

  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (rst)
    !g_n |-> !dq_oe); // R4

  AST_G_HIGH_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
    !w_n |-> (g_n && !e1_n && dq_oe)); // R3

  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack); // R6

  AST_ADDR_STILL: assert property (@(posedge clk) disable iff (rst)
    (!e1_n && !$past(e1_n)) |-> $stable(mem_addr)); // R10

  AST_W_RISES_FIRST: assert property (@(posedge clk) disable iff (rst)
    ($fell(dq_oe) && e2) |-> $past(w_n)); // R11

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(.AW(ADDR_W)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .e1_n     (mem_e1_n),
  .e2       (mem_e2),
  .w_n      (mem_w_n),
  .g_n      (mem_g_n),
  .dq_oe    (dq_oe),
  .ack      (ack),
  .mem_addr (mem_addr)
);

// File: tb/test_sram_async_ctrl.sv
`timescale 1ns/1ps
module test_sram_async_ctrl;

  localparam int AW   = 13;
  localparam int DW   = 8;
  localparam int PER  = 5000;
  localparam int TACC = 70000;
  localparam int WRP  = 3;
  localparam int RDC  = (TACC + PER - 1) / PER; // 14

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pdown = 1'b0;
  logic req = 1'b0;
  logic we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  wire ack;
  wire [DW-1:0] rdata;
  wire [AW-1:0] mem_addr;
  wire e1_n, e2, w_n, g_n;
  tri [DW-1:0] dq;

  always #2.5 clk = ~clk;

  sram_async_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_PERIOD_PS(PER),
                    .T_ACCESS_PS(TACC), .WR_PULSE_CYC(WRP)) i_sram_async_ctrl (
    .clk(clk), .rst(rst), .pdown(pdown), .req(req), .we(we), .addr(addr),
    .wdata(wdata), .ack(ack), .rdata(rdata), .mem_addr(mem_addr),
    .mem_e1_n(e1_n), .mem_e2(e2), .mem_w_n(w_n), .mem_g_n(g_n), .mem_dq(dq)
  );

  // Behavioural RAM: data appears only late in the access window.
  logic [DW-1:0] ram [int];
  int            gcnt = 0;
  logic [DW-1:0] mval = '0;
  wire           mdrv = !e1_n && e2 && !g_n && w_n && (gcnt >= RDC - 1);
  assign dq = mdrv ? mval : {DW{1'bz}};

  function automatic logic [DW-1:0] ram_rd(int a);
    return ram.exists(a) ? ram[a] : '0;
  endfunction

  always @(posedge clk) begin
    if (!e1_n && e2 && !g_n && w_n) gcnt <= gcnt + 1;
    else gcnt <= 0;
    mval <= ram_rd(int'(mem_addr));
  end

  always @(posedge w_n) if (!e1_n && e2) ram[int'(mem_addr)] = dq;

  // Reference model
  typedef struct {
    logic e1_n, w_n, g_n, ack, busy, chk_rd, commit;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    string tag;
  } vec_t;

  vec_t q[$];
  bit last_busy = 0;
  logic [DW-1:0] shadow [int];
  int vectors = 0;
  int fails = 0;

  function automatic vec_t mk(logic e1, logic w, logic g, logic k, logic b,
                              logic [AW-1:0] a, logic [DW-1:0] d,
                              logic rd, logic cm, string tag);
    vec_t v;
    v.e1_n = e1; v.w_n = w; v.g_n = g; v.ack = k; v.busy = b;
    v.a = a; v.d = d; v.chk_rd = rd; v.commit = cm; v.tag = tag;
    return v;
  endfunction

  function automatic logic [DW-1:0] sh_rd(int a);
    return shadow.exists(a) ? shadow[a] : '0;
  endfunction

  task automatic push_write(logic [AW-1:0] a, logic [DW-1:0] d);
    q.push_back(mk(1, 1, 1, 0, 1, a, d, 0, 0, "R2"));
    q.push_back(mk(0, 1, 1, 0, 1, a, d, 0, 0, "R2"));
    for (int i = 0; i < WRP; i++) q.push_back(mk(0, 0, 1, 0, 1, a, d, 0, 0, "R3"));
    q.push_back(mk(0, 1, 1, 0, 1, a, d, 0, 0, "R11"));
    q.push_back(mk(1, 1, 1, 1, 0, a, d, 0, 1, "R6"));
  endtask

  task automatic push_read(logic [AW-1:0] a);
    q.push_back(mk(1, 1, 1, 0, 1, a, 0, 0, 0, "R5"));
    for (int i = 0; i < RDC; i++) q.push_back(mk(0, 1, 0, 0, 1, a, 0, 0, 0, "R5"));
    q.push_back(mk(1, 1, 1, 1, 1, a, 0, 1, 0, "R7"));
  endtask

  task automatic fail(string tag, string what, int act, int exp);
    fails++;
    $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
  endtask

  task automatic compare(vec_t e, logic exp_e2, bit chk_a);
    vectors++;
    if (e1_n !== e.e1_n) fail(e.tag, "mem_e1_n", int'(e1_n), int'(e.e1_n));
    if (w_n  !== e.w_n)  fail(e.tag, "mem_w_n",  int'(w_n),  int'(e.w_n));
    if (g_n  !== e.g_n)  fail(e.tag, "mem_g_n",  int'(g_n),  int'(e.g_n));
    if (ack  !== e.ack)  fail(e.tag, "ack",      int'(ack),  int'(e.ack));
    if (e2   !== exp_e2) fail("R8", "mem_e2",    int'(e2),   int'(exp_e2));
    if (chk_a && mem_addr !== e.a) fail("R10", "mem_addr", int'(mem_addr), int'(e.a));
    if (e.chk_rd && rdata !== e.d) fail("R6", "rdata", int'(rdata), int'(e.d));
  endtask

  // One clock: model the edge, then compare at the following negedge.
  task automatic step(string idle_tag);
    vec_t e;
    logic exp_e2;
    bit   chk_a;
    e = mk(1, 1, 1, 0, 0, '0, '0, 0, 0, idle_tag);
    chk_a = 0;
    if (pdown) begin
      q.delete();
      last_busy = 0;
      exp_e2 = 1'b0;
      e.tag = "R8";
    end else begin
      exp_e2 = 1'b1;
      if (q.size() == 0 && !last_busy && req) begin
        if (we) push_write(addr, wdata);
        else push_read(addr);
      end
      if (q.size() > 0) begin
        e = q.pop_front();
        last_busy = e.busy;
        chk_a = 1;
        if (e.commit) shadow[int'(e.a)] = e.d;
        if (e.chk_rd) e.d = sh_rd(int'(e.a));
      end else begin
        last_busy = 0;
      end
    end
    @(negedge clk);
    compare(e, exp_e2, chk_a);
  endtask

  task automatic drain(string tag);
    while (q.size() > 0 || last_busy) step(tag);
  endtask

  task automatic xfer(logic w, logic [AW-1:0] a, logic [DW-1:0] d);
    req = 1'b1; we = w; addr = a; wdata = d;
    step("R9");
    req = 1'b0;
    drain("R9");
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    vec_t rv;
    rv = mk(1, 1, 1, 0, 0, '0, '0, 0, 0, "R1");
    @(negedge clk);
    // R1: reset state
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      compare(rv, 1'b0, 0);
    end
    rst = 1'b0;
    step("R1");

    // R2 writes incl. address boundaries
    xfer(1, 13'h0000, 8'hA5);
    xfer(1, 13'h1FFF, 8'h3C);
    xfer(1, 13'h1555, 8'hFF);
    xfer(1, 13'h0AAA, 8'h00);
    xfer(1, 13'd100,  8'h5A);
    // R5 reads back
    xfer(0, 13'h0000, 8'h00);
    xfer(0, 13'h1FFF, 8'h00);
    xfer(0, 13'h1555, 8'h00);
    xfer(0, 13'h0AAA, 8'h00);
    xfer(0, 13'd100,  8'h00);

    // R7: read then write with req held high; R9: retargeted request while busy
    req = 1'b1; we = 1'b0; addr = 13'h1555;
    step("R7");
    we = 1'b1; addr = 13'd7; wdata = 8'h77;
    while (q.size() > 0 || last_busy) step("R7");
    step("R7");
    req = 1'b0;
    drain("R7");
    xfer(0, 13'd7, 8'h00);

    // R9: request during a write pulse is ignored
    req = 1'b1; we = 1'b1; addr = 13'd20; wdata = 8'h11;
    step("R9");
    addr = 13'd21; wdata = 8'h99;
    step("R9"); step("R9"); step("R9");
    req = 1'b0;
    drain("R9");
    xfer(0, 13'd21, 8'h00);
    xfer(0, 13'd20, 8'h00);

    // R8/R9: request under power-down is ignored
    pdown = 1'b1; req = 1'b1; we = 1'b1; addr = 13'd22; wdata = 8'hEE;
    step("R8"); step("R8"); step("R8");
    pdown = 1'b0; req = 1'b0;
    step("R8");
    xfer(0, 13'd22, 8'h00);

    // R8: power-down during a read abandons it without ack
    req = 1'b1; we = 1'b0; addr = 13'h1FFF;
    step("R8");
    req = 1'b0;
    step("R8"); step("R8");
    pdown = 1'b1;
    step("R8"); step("R8");
    pdown = 1'b0;
    step("R8"); step("R8");

    // R8: power-down before the write strobe leaves memory unchanged
    req = 1'b1; we = 1'b1; addr = 13'h0000; wdata = 8'h42;
    step("R8");
    req = 1'b0;
    step("R8");
    pdown = 1'b1;
    step("R8");
    pdown = 1'b0;
    step("R8");
    xfer(0, 13'h0000, 8'h00);

    summary();
    $finish;
  end

endmodule